// File: doc/BRIEF.md
# Indexed Clock Register Port

This block is the host-facing register front end of a real-time clock. A byte-wide host reaches a 128-byte register file through two addresses. A write to the even address selects a register index. An access to the odd address then reads or writes the selected register. Most of the file is plain storage. The ten time and alarm bytes at the bottom are exported to the calendar logic, which can write them back after each update.

Four control registers at indices 10 to 13 follow their own rules:
- Register 10 holds an update-in-progress flag that the host cannot change.
- Register 11 holds a freeze bit that suppresses the update-ended interrupt enable.
- Register 12 holds the flags. It clears when read, and its top bit drives the interrupt line.
- Register 13 is read-only.

A synchronous reset event clears the interrupt enables and flags without disturbing the time.

Host accesses are single-cycle strobes. There is no back-pressure: every access is accepted in the cycle it is presented. Read data comes back with a one-cycle valid pulse. The calendar and periodic logic connect through plain pins:
- an update-in-progress set input and an update-in-progress clear input,
- a flag-set byte,
- a byte-write port into storage,
- a reload pulse that tells the calendar to take the time bytes as the new running time.

Top module: `clkreg_port`

## Requirements
- R1: A write to the even address stores bits 6:0 of the data as the register index; bit 7 is discarded.
- R2: A read from the even address returns 0xFF.
- R3: Bit 7 of register 10 (update in progress) ignores host writes; the other seven bits take the written value.
- R4: A write to register 11 with bit 7 (freeze) set stores bit 4 (update-ended interrupt enable) as 0, and clears bit 7 of register 10.
- R5: Host writes to register 12 and register 13 leave them unchanged.
- R6: Reading register 12 returns its value, then clears it to 0x00 one cycle later, which drops `irq_o` (`irq_o` follows bit 7 of register 12). Flags set by `flag_set` in the same cycle as the read survive.
- R7: After `rst_n`, the registers hold 10=0x26, 11=0x02, 12=0x00, 13=0x80, `irq_o` is low and `rd_valid` is low.
- R8: A `sys_evt` pulse clears bits 6, 5 and 3 of register 11 and bits 7:4 of register 12, taking priority over a same-cycle flag set.
- R9: `time_reload` pulses one cycle after either of two host events: a write to any of indices 0, 2, 4, 6, 7, 8 or 9 while freeze is clear, or a write to register 11 that clears freeze when it was set. A time write while freeze is set gives no pulse.
- R10: Indices 0 to 9 and 14 to 127 are plain read/write bytes.
- R11: `rd_valid` and `rd_data` are presented in the cycle after an accepted read.
- R12: `uip_set` has no effect while freeze is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, loads register reset values |
| sys_evt | input | 1 | Synchronous reset event for enables and flags |
| acc_en | input | 1 | Host access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_odd | input | 1 | 1 = data address, 0 = index address |
| acc_wdata | input | 8 | Host write data |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 8 | Read data |
| uip_set | input | 1 | Calendar: update started |
| uip_clr | input | 1 | Calendar: update finished |
| flag_set | input | 8 | Bits ORed into register 12 |
| cal_wr | input | 1 | Calendar byte-write strobe |
| cal_idx | input | 7 | Calendar write index |
| cal_data | input | 8 | Calendar write data |
| ctrl_a | output | 8 | Register 10 contents |
| ctrl_b | output | 8 | Register 11 contents |
| irq_o | output | 1 | Interrupt line |
| time_reload | output | 1 | Reload-running-time pulse |
| time_regs | output | 80 | Bytes at indices 0..9, index 0 in bits 7:0 |

## Verification
Every host access is registered once:
- A write changes the index, a register or `time_reload` after the next rising edge.
- Read data and `rd_valid` appear after the edge that accepts the read.
- Register 12 is already zero in that same cycle, so `irq_o` falls together with the returned flags.

Inputs from the calendar side (`flag_set`, `uip_set`, `sys_evt`) also take effect one edge later.

The bench drives each stimulus on a falling edge and holds it through one rising edge. It samples on the following falling edge, which is the one cycle where each of these results is due. A value a read returns is the state before that read.

// File: rtl/clkreg_pkg.sv
`timescale 1ns/1ps
package clkreg_pkg;
  localparam int DATA_W   = 8;
  localparam int IDX_W    = 7;
  localparam int DEPTH    = 1 << IDX_W;
  localparam int NUM_TIME = 10;

  localparam logic [IDX_W-1:0] IDX_A = 7'd10;
  localparam logic [IDX_W-1:0] IDX_B = 7'd11;
  localparam logic [IDX_W-1:0] IDX_C = 7'd12;
  localparam logic [IDX_W-1:0] IDX_D = 7'd13;

  localparam logic [DATA_W-1:0] RST_A = 8'h26;
  localparam logic [DATA_W-1:0] RST_B = 8'h02;
  localparam logic [DATA_W-1:0] RST_C = 8'h00;
  localparam logic [DATA_W-1:0] RST_D = 8'h80;

  localparam int BIT_UIP    = 7;
  localparam int BIT_FREEZE = 7;
  localparam int BIT_UEN    = 4;
  localparam logic [DATA_W-1:0] EVT_B_MASK = 8'h68;
  localparam logic [DATA_W-1:0] EVT_C_MASK = 8'hF0;
  localparam int BIT_IRQ = 7;

  // indices whose write reloads the running time (bit i = index i)
  localparam logic [NUM_TIME-1:0] TIME_MASK = 10'b11_1101_0101;
endpackage

// File: rtl/clkreg_index.sv
`timescale 1ns/1ps
module clkreg_index
  import clkreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [IDX_W-1:0]  idx,
  output logic              is_ctrl,
  output logic              is_time
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx <= '0;
    else if (idx_wr) idx <= wdata[IDX_W-1:0];
  end

  assign is_ctrl = (idx >= IDX_A) && (idx <= IDX_D);
  assign is_time = (idx < IDX_W'(NUM_TIME)) && TIME_MASK[idx[3:0]];

  // R1: index takes the low seven bits of the written byte
  a_r1_index_mask: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> idx == $past(wdata[IDX_W-1:0]));
endmodule

// File: rtl/clkreg_ctrl.sv
`timescale 1ns/1ps
module clkreg_ctrl
  import clkreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_evt,
  input  logic              wr_a,
  input  logic              wr_b,
  input  logic              rd_c,
  input  logic [DATA_W-1:0] wdata,
  input  logic              uip_set,
  input  logic              uip_clr,
  input  logic [DATA_W-1:0] flag_set,
  output logic [DATA_W-1:0] reg_a,
  output logic [DATA_W-1:0] reg_b,
  output logic [DATA_W-1:0] reg_c,
  output logic [DATA_W-1:0] reg_d,
  output logic              freeze_off
);
  logic [DATA_W-1:0] a_n, b_n, c_n;
  logic uip_n;

  assign freeze_off = wr_b && !wdata[BIT_FREEZE] && reg_b[BIT_FREEZE];

  always_comb begin
    if (wr_b && wdata[BIT_FREEZE])   uip_n = 1'b0;
    else if (uip_clr)                uip_n = 1'b0;
    else if (uip_set && !reg_b[BIT_FREEZE]) uip_n = 1'b1;
    else                             uip_n = reg_a[BIT_UIP];

    a_n = wr_a ? wdata : reg_a;
    a_n[BIT_UIP] = uip_n;

    b_n = reg_b;
    if (wr_b) begin
      b_n = wdata;
      if (wdata[BIT_FREEZE]) b_n[BIT_UEN] = 1'b0;
    end
    if (sys_evt) b_n = b_n & ~EVT_B_MASK;

    c_n = (rd_c ? '0 : reg_c) | flag_set;
    if (sys_evt) c_n = c_n & ~EVT_C_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_a <= RST_A;
      reg_b <= RST_B;
      reg_c <= RST_C;
      reg_d <= RST_D;
    end else begin
      reg_a <= a_n;
      reg_b <= b_n;
      reg_c <= c_n;
    end
  end

  // R3: host write keeps update-in-progress
  a_r3_uip_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_a && !uip_set && !uip_clr) |=> reg_a[BIT_UIP] == $past(reg_a[BIT_UIP]));
  // R4: freeze write clears enable and update-in-progress
  a_r4_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_b && wdata[BIT_FREEZE]) |=> !reg_b[BIT_UEN] && !reg_a[BIT_UIP]);
  // R6: read with no new flags empties the register
  a_r6_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && flag_set == '0) |=> reg_c == '0);
  // R8: reset event clears enables and flags
  a_r8_evt: assert property (@(posedge clk) disable iff (!rst_n)
    sys_evt |=> ((reg_b & EVT_B_MASK) == '0) && ((reg_c & EVT_C_MASK) == '0));
  // R12: update start ignored while frozen
  a_r12_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_b[BIT_FREEZE] && !reg_a[BIT_UIP] && !wr_b) |=> !reg_a[BIT_UIP]);
endmodule

// File: rtl/clkreg_store.sv
`timescale 1ns/1ps
module clkreg_store
  import clkreg_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [IDX_W-1:0]           widx,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [IDX_W-1:0]           ridx,
  output logic [DATA_W-1:0]          rdata,
  output logic [NUM_TIME*DATA_W-1:0] time_bytes
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  assign rdata = mem[ridx];

  for (genvar g = 0; g < NUM_TIME; g++) begin : g_time
    assign time_bytes[g*DATA_W +: DATA_W] = mem[g];
  end
endmodule

// File: rtl/clkreg_port.sv
`timescale 1ns/1ps
module clkreg_port
  import clkreg_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sys_evt,
  input  logic                       acc_en,
  input  logic                       acc_wr,
  input  logic                       acc_odd,
  input  logic [DATA_W-1:0]          acc_wdata,
  output logic                       rd_valid,
  output logic [DATA_W-1:0]          rd_data,
  input  logic                       uip_set,
  input  logic                       uip_clr,
  input  logic [DATA_W-1:0]          flag_set,
  input  logic                       cal_wr,
  input  logic [IDX_W-1:0]           cal_idx,
  input  logic [DATA_W-1:0]          cal_data,
  output logic [DATA_W-1:0]          ctrl_a,
  output logic [DATA_W-1:0]          ctrl_b,
  output logic                       irq_o,
  output logic                       time_reload,
  output logic [NUM_TIME*DATA_W-1:0] time_regs
);
  logic [IDX_W-1:0]  idx;
  logic              is_ctrl, is_time, freeze_off;
  logic [DATA_W-1:0] reg_a, reg_b, reg_c, reg_d, mem_rd, sel_val;
  logic              host_rd, host_dwr, host_drd, st_we;
  logic [IDX_W-1:0]  st_idx;
  logic [DATA_W-1:0] st_data;

  assign host_rd  = acc_en && !acc_wr;
  assign host_dwr = acc_en && acc_wr && acc_odd;
  assign host_drd = host_rd && acc_odd;

  clkreg_index u_idx (
    .clk(clk), .rst_n(rst_n), .idx_wr(acc_en && acc_wr && !acc_odd),
    .wdata(acc_wdata), .idx(idx), .is_ctrl(is_ctrl), .is_time(is_time));

  clkreg_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .sys_evt(sys_evt),
    .wr_a(host_dwr && idx == IDX_A), .wr_b(host_dwr && idx == IDX_B),
    .rd_c(host_drd && idx == IDX_C), .wdata(acc_wdata),
    .uip_set(uip_set), .uip_clr(uip_clr), .flag_set(flag_set),
    .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c), .reg_d(reg_d),
    .freeze_off(freeze_off));

  // host write has priority over the calendar port
  assign st_we   = (host_dwr && !is_ctrl) || cal_wr;
  assign st_idx  = (host_dwr && !is_ctrl) ? idx : cal_idx;
  assign st_data = (host_dwr && !is_ctrl) ? acc_wdata : cal_data;

  clkreg_store u_store (
    .clk(clk), .rst_n(rst_n), .we(st_we), .widx(st_idx), .wdata(st_data),
    .ridx(idx), .rdata(mem_rd), .time_bytes(time_regs));

  always_comb begin
    case (idx)
      IDX_A:   sel_val = reg_a;
      IDX_B:   sel_val = reg_b;
      IDX_C:   sel_val = reg_c;
      IDX_D:   sel_val = reg_d;
      default: sel_val = mem_rd;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid    <= 1'b0;
      rd_data     <= '0;
      time_reload <= 1'b0;
    end else begin
      rd_valid    <= host_rd;
      if (host_rd) rd_data <= acc_odd ? sel_val : 8'hFF;
      time_reload <= (host_dwr && is_time && !reg_b[BIT_FREEZE]) || freeze_off;
    end
  end

  assign ctrl_a = reg_a;
  assign ctrl_b = reg_b;
  assign irq_o  = reg_c[BIT_IRQ];

  // R2: index address reads as all ones
  a_r2_even_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !acc_odd) |=> rd_data == 8'hFF);
  // R11: data valid exactly one cycle after a read
  a_r11_rd_valid: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd |=> rd_valid);
  // R9: no reload while frozen unless freeze is being cleared
  a_r9_frozen_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_b[BIT_FREEZE] && !(acc_en && acc_wr)) |=> !time_reload);
endmodule

// File: tb/tb_clkreg_port.sv
`timescale 1ns/1ps
module tb_clkreg_port;
  logic clk = 1'b0, rst_n = 1'b0, sys_evt = 1'b0;
  logic acc_en = 1'b0, acc_wr = 1'b0, acc_odd = 1'b0;
  logic [7:0] acc_wdata = '0;
  logic rd_valid, irq_o, time_reload;
  logic [7:0] rd_data, ctrl_a, ctrl_b;
  logic uip_set = 1'b0, uip_clr = 1'b0, cal_wr = 1'b0;
  logic [7:0] flag_set = '0, cal_data = '0;
  logic [6:0] cal_idx = '0;
  logic [79:0] time_regs;

  int checks = 0, fails = 0;
  logic [7:0] got;
  logic last_reload;

  always #4 clk = ~clk;

  clkreg_port dut (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic odd, input logic [7:0] d);
    @(negedge clk);
    acc_en = 1; acc_wr = 1; acc_odd = odd; acc_wdata = d;
    @(negedge clk);
    last_reload = time_reload;
    acc_en = 0; acc_wr = 0;
  endtask

  task automatic rd(input logic odd, output logic [7:0] v);
    @(negedge clk);
    acc_en = 1; acc_wr = 0; acc_odd = odd;
    @(negedge clk);
    acc_en = 0;
    v = rd_data;
    checks++;
    if (rd_valid !== 1'b1) begin
      fails++;
      $display("FAIL R11 rd_valid actual=%0b expected=1", rd_valid);
    end
  endtask

  task automatic pulse_in(input logic us, input logic [7:0] fl, input logic ev);
    @(negedge clk);
    uip_set = us; flag_set = fl; sys_evt = ev;
    @(negedge clk);
    uip_set = 0; flag_set = '0; sys_evt = 0;
  endtask

  // {op[1:0] (0 idx write,1 data write,2 idx read,3 data read), req[3:0], data, expected}
  localparam int NV = 16;
  localparam logic [21:0] VEC [NV] = '{
    {2'd2, 4'd2,  8'h00, 8'hFF},
    {2'd0, 4'd1,  8'h8A, 8'h00},
    {2'd3, 4'd1,  8'h00, 8'h26},
    {2'd1, 4'd3,  8'hFF, 8'h00},
    {2'd3, 4'd3,  8'h00, 8'h7F},
    {2'd0, 4'd7,  8'h0B, 8'h00},
    {2'd3, 4'd7,  8'h00, 8'h02},
    {2'd0, 4'd7,  8'h0D, 8'h00},
    {2'd1, 4'd5,  8'h00, 8'h00},
    {2'd3, 4'd5,  8'h00, 8'h80},
    {2'd0, 4'd10, 8'h20, 8'h00},
    {2'd1, 4'd10, 8'h5A, 8'h00},
    {2'd3, 4'd10, 8'h00, 8'h5A},
    {2'd0, 4'd4,  8'h0B, 8'h00},
    {2'd1, 4'd4,  8'h92, 8'h00},
    {2'd3, 4'd4,  8'h00, 8'h82}
  };

  initial begin
    #(8 * 100000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R7: reset state at the pins
    check("R7 irq", {7'd0, irq_o}, 8'h00);
    check("R7 rd_valid", {7'd0, rd_valid}, 8'h00);
    check("R7 ctrl_a", ctrl_a, 8'h26);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      op = VEC[i][21:20];
      if (op[1] == 1'b0) wr(op[0], VEC[i][15:8]);
      else begin
        rd(op[0], got);
        check($sformatf("R%0d vec%0d", VEC[i][19:16], i), got, VEC[i][7:0]);
      end
    end

    // R12: update start ignored while frozen (B = 0x82)
    pulse_in(1, 8'h00, 0);
    wr(0, 8'h0A); rd(1, got); check("R12 uip while frozen", got, 8'h7F);

    // R9: clearing freeze reloads the time
    wr(0, 8'h0B); wr(1, 8'h02);
    check("R9 reload on freeze clear", {7'd0, last_reload}, 8'h01);

    // R3: UIP set by calendar survives a host write of register 10
    pulse_in(1, 8'h00, 0);
    wr(0, 8'h0A); wr(1, 8'h26); rd(1, got); check("R3 uip kept", got, 8'hA6);

    // R4: freeze write clears UIP
    wr(0, 8'h0B); wr(1, 8'h80);
    wr(0, 8'h0A); rd(1, got); check("R4 uip cleared", got, 8'h26);

    // R9: time write with freeze clear reloads, with freeze set does not
    wr(0, 8'h0B); wr(1, 8'h02);
    wr(0, 8'h00); wr(1, 8'h45);
    check("R9 reload on time write", {7'd0, last_reload}, 8'h01);
    check("R10 time byte 0", time_regs[7:0], 8'h45);
    wr(0, 8'h0B); wr(1, 8'h82);
    wr(0, 8'h00); wr(1, 8'h11);
    check("R9 no reload while frozen", {7'd0, last_reload}, 8'h00);
    wr(0, 8'h0B); wr(1, 8'h02);

    // R6: flags raise irq, read returns and clears them
    pulse_in(0, 8'hC0, 0);
    check("R6 irq raised", {7'd0, irq_o}, 8'h01);
    wr(0, 8'h0C); rd(1, got);
    check("R6 read value", got, 8'hC0);
    check("R6 irq lowered", {7'd0, irq_o}, 8'h00);
    rd(1, got); check("R6 cleared", got, 8'h00);

    // R5: writes to flag register ignored
    wr(1, 8'hFF); rd(1, got); check("R5 reg12 write", got, 8'h00);

    // R8: reset event clears enables and flags
    wr(0, 8'h0B); wr(1, 8'h6A);
    pulse_in(0, 8'hF0, 0);
    pulse_in(0, 8'h00, 1);
    rd(1, got); check("R8 reg11", got, 8'h02);
    wr(0, 8'h0C); rd(1, got); check("R8 reg12", got, 8'h00);
    check("R8 irq", {7'd0, irq_o}, 8'h00);

    // R10: top storage byte
    wr(0, 8'h7F); wr(1, 8'hC3); rd(1, got); check("R10 index 127", got, 8'hC3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule